// File: doc/BRIEF.md
# Switch Input Port with Entry-Complete Latch

This block is a slave on a small processor bus that has an 8-bit bidirectional data bus, an 11-bit I/O address and active-low read and write strobes. It presents a bank of eight switches at one fully decoded I/O address. While the read strobe is low at that address, it drives the switch states onto the data bus. The upper nibble reads as 1 for a closed switch and the lower nibble reads as 0 for a closed switch. At all other times the block releases the bus.

A second address carries a handshake. The operator sets the switches and then presses a push button, which sets a ready flag. Software polls the flag by reading the status address. After it has taken the switch data, software clears the flag by writing to the same address. This ensures that software reads the switches only after entry is complete.

The switch and button lines are asynchronous. Each passes through a two-stage synchronizer before use, and no debouncing is done. The bus strobes and the address are taken as synchronous to the block clock for the clear path. The read path is combinational from the strobe and the address to the bus drivers.

Top module: `sw_input_port`

## Requirements
- R1: The switch data is driven only for io_addr exactly 0x1A7, with all 11 bits compared. A read at any other address except 0x1A8, including 0x1A6, 0x1A9, 0x0A7 and 0x5A7, leaves the bus released.
- R2: Data bits 7..4 read 1 when the matching switch input (sw_closed bit = 1) is closed and 0 when it is open.
- R3: Data bits 3..0 read 0 when the matching switch is closed and 1 when it is open.
- R4: io_data is driven by the block only while rd_n is low at 0x1A7 or 0x1A8. A low wr_n never makes the block drive, and the value placed on the bus by the bus master is left untouched.
- R5: A read at 0x1A8 returns the ready flag on bit 0, with bits 7..1 equal to 0.
- R6: A synchronized high on done_btn sets the ready flag on the next clock edge, and the flag stays set after the button is released.
- R7: A write (wr_n low at a clock edge) to 0x1A8 with data bit 0 = 1 clears the flag. A write there with bit 0 = 0, or a write with bit 0 = 1 to any other address, leaves the flag unchanged.
- R8: If the synchronized button is high in the same cycle as a clearing write, the flag is set. The set wins.
- R9: A change on sw_closed or done_btn first has its effect after the second rising clock edge that samples it.
- R10: While rst_n is low, the flag and both synchronizer stages are cleared. After reset, every switch reads as open (data 0x0F) and the status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 11 | I/O address from the bus master |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| io_data | inout | 8 | Shared data bus |
| sw_closed | input | 8 | Raw switch states, 1 = closed |
| done_btn | input | 1 | Raw push button, 1 = pressed |

## Verification
The checker assumes that rd_n and wr_n are never low together. It also assumes that, during a write, the bus master holds io_data steady around the clock edge, so the sampled bit 0 is the intended clear command. The bench drives every input on the falling clock edge, never asserts both strobes together, and places data on the bus only while wr_n is low. It therefore stays inside these assumptions. Clear checks compare the flag against a queue-based model that holds the two-edge synchronizer delay explicitly.

// File: rtl/sw_port_pkg.sv
package sw_port_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned IOA_W  = 11;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2
  } port_sel_e;
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int unsigned WIDTH  = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/sw_addr_decode.sv
module sw_addr_decode
  import sw_port_pkg::*;
#(
  parameter int unsigned           AW        = IOA_W,
  parameter logic [IOA_W-1:0]      DATA_ADDR = 11'h1A7,
  parameter logic [IOA_W-1:0]      STAT_ADDR = 11'h1A8
) (
  input  logic [AW-1:0] addr_i,
  output port_sel_e     sel_o
);
  always_comb begin
    if (addr_i == DATA_ADDR[AW-1:0])      sel_o = SEL_DATA;
    else if (addr_i == STAT_ADDR[AW-1:0]) sel_o = SEL_STAT;
    else                                  sel_o = SEL_NONE;
  end
endmodule

// File: rtl/sw_ready_latch.sv
module sw_ready_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic rdy_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdy_o <= 1'b0;
    else if (set_i) rdy_o <= 1'b1;
    else if (clr_i) rdy_o <= 1'b0;
  end
endmodule

// File: rtl/sw_input_port.sv
module sw_input_port
  import sw_port_pkg::*;
#(
  parameter int unsigned      DW          = BUS_W,
  parameter int unsigned      AW          = IOA_W,
  parameter logic [IOA_W-1:0] DATA_ADDR   = 11'h1A7,
  parameter logic [IOA_W-1:0] STAT_ADDR   = 11'h1A8,
  parameter logic [BUS_W-1:0] CLOSED_HIGH = 8'hF0,
  parameter int unsigned      SYNC_DEPTH  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          rd_n,
  input  logic          wr_n,
  inout  wire  [DW-1:0] io_data,
  input  logic [DW-1:0] sw_closed,
  input  logic          done_btn
);
  localparam int unsigned SYNC_W = DW + 1;

  logic [SYNC_W-1:0] sync_q;
  logic [DW-1:0]     sw_s;
  logic              btn_s;
  port_sel_e         sel;
  logic              rdy;
  logic              clr_req;
  logic              bus_oe;
  logic [DW-1:0]     bus_out;

  sw_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({done_btn, sw_closed}),
    .sync_o (sync_q)
  );

  assign sw_s  = sync_q[DW-1:0];
  assign btn_s = sync_q[DW];

  sw_addr_decode #(.AW(AW), .DATA_ADDR(DATA_ADDR), .STAT_ADDR(STAT_ADDR)) u_dec (
    .addr_i (io_addr),
    .sel_o  (sel)
  );

  assign clr_req = !wr_n && (sel == SEL_STAT) && io_data[0];

  sw_ready_latch u_rdy (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (btn_s),
    .clr_i (clr_req),
    .rdy_o (rdy)
  );

  // Closed switch reads 1 where the mask bit is 1, else 0.
  always_comb begin
    unique case (sel)
      SEL_DATA: bus_out = ~(sw_s ^ CLOSED_HIGH[DW-1:0]);
      SEL_STAT: bus_out = {{(DW-1){1'b0}}, rdy};
      default:  bus_out = '0;
    endcase
  end

  assign bus_oe  = !rd_n && (sel != SEL_NONE);
  assign io_data = bus_oe ? bus_out : {DW{1'bz}};
endmodule

// File: rtl/sw_input_port_chk.sv
module sw_input_port_chk #(
  parameter int unsigned DW        = 8,
  parameter int unsigned AW        = 11,
  parameter logic [10:0] DATA_ADDR = 11'h1A7,
  parameter logic [10:0] STAT_ADDR = 11'h1A8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] io_addr,
  input logic          rd_n,
  input logic          wr_n,
  input logic [DW-1:0] io_data,
  input logic          bus_oe,
  input logic [DW-1:0] bus_out,
  input logic          btn_s,
  input logic          rdy
);
  logic at_data, at_stat;
  assign at_data = (io_addr == DATA_ADDR[AW-1:0]);
  assign at_stat = (io_addr == STAT_ADDR[AW-1:0]);

  // R1, R4: released unless a read hits one of the two addresses
  a_r1_released: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || (!at_data && !at_stat)) |-> !bus_oe);

  // R4: a read of the data address drives the bus
  a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && at_data) |-> bus_oe);

  // R5: status upper bits are zero
  a_r5_status_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && at_stat) |-> (bus_out[DW-1:1] == '0));

  // R6, R8: synchronized button sets the flag, even against a clear
  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    btn_s |=> rdy);

  // R7: clearing write without button clears
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!btn_s && !wr_n && rd_n && at_stat && io_data[0]) |=> !rdy);

  // R7: no button and no write keeps the flag
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!btn_s && wr_n) |=> $stable(rdy));
endmodule

bind sw_input_port sw_input_port_chk #(
  .DW(DW), .AW(AW), .DATA_ADDR(DATA_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .io_addr (io_addr),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .io_data (io_data),
  .bus_oe  (bus_oe),
  .bus_out (bus_out),
  .btn_s   (btn_s),
  .rdy     (rdy)
);

// File: tb/test_sw_input_port.sv
`timescale 1ns/1ps
module test_sw_input_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = 11'h000;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [7:0]  sw = 8'h00;
  logic        btn = 1'b0;
  logic        tb_drv = 1'b0;
  logic [7:0]  tb_wval = 8'h00;
  wire  [7:0]  bus;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  assign bus = tb_drv ? tb_wval : 8'hzz;
  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup pu (bus[i]);
  end

  sw_input_port i_sw_input_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (addr),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .io_data   (bus),
    .sw_closed (sw),
    .done_btn  (btn)
  );

  // Reference model: queue of sampled {btn, sw}, oldest entry is visible.
  logic [8:0] pipe [$];
  logic       m_rdy;

  initial begin
    pipe = '{9'h000, 9'h000};
    m_rdy = 1'b0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe = '{9'h000, 9'h000};
      m_rdy = 1'b0;
    end else begin
      if (pipe[0][8])
        m_rdy = 1'b1;
      else if (!wr_n && addr == 11'h1A8 && bus[0] === 1'b1)
        m_rdy = 1'b0;
      void'(pipe.pop_front());
      pipe.push_back({btn, sw});
    end
  end

  function automatic logic [7:0] model_bus();
    if (!rd_n && addr == 11'h1A7) return ~(pipe[0][7:0] ^ 8'hF0);
    if (!rd_n && addr == 11'h1A8) return {7'b0, m_rdy};
    if (!wr_n)                    return tb_wval;
    return 8'hFF;
  endfunction

  task automatic cyc(input logic [10:0] a, input logic r, input logic w,
                     input logic [7:0] wv, input string tag);
    logic [7:0] exp_v;
    @(negedge clk);
    addr = a; rd_n = r; wr_n = w; tb_drv = !w; tb_wval = wv;
    #1;
    exp_v = model_bus();
    checks++;
    if (bus !== exp_v) begin
      fails++;
      $display("FAIL %s addr=%h rd_n=%b wr_n=%b actual=%h expected=%h",
               tag, a, r, w, bus, exp_v);
    end
  endtask

  task automatic rd(input logic [10:0] a, input string tag);
    cyc(a, 1'b0, 1'b1, 8'h00, tag);
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] v, input string tag);
    cyc(a, 1'b1, 1'b0, v, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(11'h000, 1'b1, 1'b1, 8'h00, tag);
  endtask

  initial begin
    // R10: state held in reset, then released
    sw = 8'hFF; btn = 1'b1;
    idle(3, "R10");
    sw = 8'h00; btn = 1'b0;
    idle(3, "R10");
    @(negedge clk); rst_n = 1'b1;
    rd(11'h1A7, "R10");
    rd(11'h1A8, "R10");

    // R2, R3: all closed, then patterns
    sw = 8'hFF;
    rd(11'h1A7, "R9");
    rd(11'h1A7, "R9");
    rd(11'h1A7, "R2");
    sw = 8'hA5;
    idle(2, "R9");
    rd(11'h1A7, "R3");
    sw = 8'h3C;
    idle(2, "R9");
    rd(11'h1A7, "R2");
    sw = 8'hC3;
    idle(2, "R9");
    rd(11'h1A7, "R3");

    // R1: near-miss addresses leave bus released
    rd(11'h1A6, "R1");
    rd(11'h1A9, "R1");
    rd(11'h0A7, "R1");
    rd(11'h5A7, "R1");
    rd(11'h1B7, "R1");
    rd(11'h1A7, "R1");

    // R4: writes to the data address do not drive
    wr(11'h1A7, 8'h5A, "R4");
    wr(11'h1A7, 8'h00, "R4");
    idle(1, "R4");

    // R6: button press sets, stays after release
    btn = 1'b1;
    rd(11'h1A8, "R9");
    rd(11'h1A8, "R9");
    rd(11'h1A8, "R6");
    btn = 1'b0;
    idle(3, "R6");
    rd(11'h1A8, "R6");
    rd(11'h1A8, "R5");

    // R7: non-clearing writes, then clear
    wr(11'h1A8, 8'hFE, "R7");
    rd(11'h1A8, "R7");
    wr(11'h1A9, 8'h01, "R7");
    wr(11'h1A7, 8'h01, "R7");
    rd(11'h1A8, "R7");
    wr(11'h1A8, 8'h01, "R7");
    rd(11'h1A8, "R7");
    rd(11'h1A8, "R5");

    // R8: set wins over clear
    btn = 1'b1;
    idle(2, "R8");
    wr(11'h1A8, 8'h01, "R8");
    rd(11'h1A8, "R8");
    wr(11'h1A8, 8'hFF, "R8");
    rd(11'h1A8, "R8");
    btn = 1'b0;
    idle(3, "R8");
    wr(11'h1A8, 8'h01, "R7");
    rd(11'h1A8, "R7");

    // Mixed sweep
    for (int v = 0; v < 64; v++) begin
      sw = 8'(v * 37 + 11);
      btn = (v % 9) == 0;
      cyc(11'h1A7, v[0], 1'b1, 8'h00, "R2");
      cyc(11'h1A8, v[1], 1'b1, 8'h00, "R5");
      cyc(11'h1A8, 1'b1, v[2], 8'(v), "R7");
    end
    btn = 1'b0;
    idle(3, "R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule